// File: doc/BRIEF.md
# Shared Memory Port Stall Arbiter

This block sits between a five-stage in-order pipeline and one single-ported unified memory. Every cycle, the instruction-fetch stage may ask for an instruction word and the memory-access stage may ask for a load or a store. Only loads and stores reach the data side; ALU operations and branches present no request. When both sides ask in the same cycle, the older instruction in the memory-access stage takes the port. The fetch is held off for that cycle. The arbiter raises a stall that freezes the program counter and the fetch/decode pipeline register. One cycle later, when the fetched word would have come back, it presents a no-operation word and flags that a bubble enters decode.

The request side uses valid/ready. The data requester always sees ready high, so it never waits. The fetch requester sees ready low in any cycle where a data request is present. While ready is low it must keep valid high and the address unchanged, and it retries in the next cycle. The memory has one cycle of read latency. The arbiter registers a tag for the grant along with the access and uses it to send the returned word to whichever requester held the port. Responses have no back-pressure: a response valid lasts one cycle and the requester must take it. A saturating counter of stall cycles lets the cost per load or store be measured.

Top module: `shmem_arbiter`

## Requirements
- R1: After reset, the memory enable, both response valids and the bubble flag are low, and the stall count is zero.
- R2: A data request is always accepted in its cycle (dm_req_ready = 1). The memory port then carries its address, write enable and write data, with mem_en = 1.
- R3: With only a fetch request present, the memory port reads at the fetch address (mem_en = 1, mem_we = 0), if_req_ready = 1 and fetch_stall = 0.
- R4: When fetch and data requests collide, the data request drives the memory port, if_req_ready = 0 and fetch_stall = 1.
- R5: One cycle after a granted read, the memory word appears on the response of the requester that was granted. A fetch read raises if_rsp_valid and a load raises dm_rsp_valid. A store raises neither response valid, and the two valids are never high together.
- R6: In the cycle after a collision, id_bubble = 1, if_rsp_valid = 0 and if_rsp_data equals the no-operation word (all zeros by default, so every write enable is clear).
- R7: stall_count rises by exactly one for each collision cycle and holds at its all-ones maximum.
- R8: A fetch that was stalled and is retried with the same address in a cycle without a data request returns the word at that address. The collision therefore costs exactly one extra cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| if_req_valid | input | 1 | Fetch request present |
| if_req_ready | output | 1 | Fetch granted this cycle |
| if_addr | input | AW | Fetch word address |
| dm_req_valid | input | 1 | Load or store request present |
| dm_req_ready | output | 1 | Data request accepted (always 1) |
| dm_we | input | 1 | 1 = store, 0 = load |
| dm_addr | input | AW | Data word address |
| dm_wdata | input | DW | Store data |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, one cycle after the access |
| if_rsp_valid | output | 1 | Fetched word valid |
| if_rsp_data | output | DW | Fetched word, or the no-operation word during a bubble |
| dm_rsp_valid | output | 1 | Load data valid |
| dm_rsp_data | output | DW | Load data |
| fetch_stall | output | 1 | Hold the program counter and the fetch/decode register |
| id_bubble | output | 1 | A bubble enters decode this cycle |
| stall_count | output | CW | Saturating count of collision cycles |

## Verification
The bench sweeps every combination of fetch request, data request and load/store over several address patterns. Against a shadow memory it checks the port steering and the routing of each response. A design that let fetch win a collision would read from the wrong address, or lose a store. A design that sent the read word by the current grant instead of the registered one would hand load data to fetch. The bench also runs a long run of back-to-back collisions past the count limit, where a counter that wraps would fall back to zero. It checks a stalled fetch followed by its retry, which catches a bubble that lasts two cycles or a retry that returns stale data.

// File: rtl/shmem_arbiter_pkg.sv
package shmem_arbiter_pkg;
  typedef enum logic [1:0] {
    GNT_IDLE  = 2'd0,
    GNT_FETCH = 2'd1,
    GNT_LOAD  = 2'd2,
    GNT_STORE = 2'd3
  } grant_e;
endpackage

// File: rtl/shmem_grant_logic.sv
module shmem_grant_logic
  import shmem_arbiter_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          f_valid,
  input  logic [AW-1:0] f_addr,
  input  logic          d_valid,
  input  logic          d_we,
  input  logic [AW-1:0] d_addr,
  input  logic [DW-1:0] d_wdata,
  output grant_e        grant,
  output logic          f_ready,
  output logic          collide,
  output logic          port_en,
  output logic          port_we,
  output logic [AW-1:0] port_addr,
  output logic [DW-1:0] port_wdata
);
  always_comb begin
    grant      = GNT_IDLE;
    port_en    = 1'b0;
    port_we    = 1'b0;
    port_addr  = f_addr;
    port_wdata = '0;
    if (d_valid) begin
      grant      = d_we ? GNT_STORE : GNT_LOAD;
      port_en    = 1'b1;
      port_we    = d_we;
      port_addr  = d_addr;
      port_wdata = d_wdata;
    end else if (f_valid) begin
      grant   = GNT_FETCH;
      port_en = 1'b1;
    end
  end

  assign f_ready = ~d_valid;
  assign collide = f_valid & d_valid;
endmodule

// File: rtl/shmem_resp_router.sv
module shmem_resp_router
  import shmem_arbiter_pkg::*;
#(
  parameter int               DW          = 32,
  parameter logic [DW-1:0]    BUBBLE_WORD = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  grant_e        grant,
  input  logic          collide,
  input  logic [DW-1:0] rdata,
  output logic          f_rsp_valid,
  output logic [DW-1:0] f_rsp_data,
  output logic          d_rsp_valid,
  output logic [DW-1:0] d_rsp_data,
  output logic          bubble
);
  grant_e tag_q;
  logic   bubble_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag_q    <= GNT_IDLE;
      bubble_q <= 1'b0;
    end else begin
      tag_q    <= grant;
      bubble_q <= collide;
    end
  end

  assign f_rsp_valid = (tag_q == GNT_FETCH);
  assign d_rsp_valid = (tag_q == GNT_LOAD);
  assign f_rsp_data  = bubble_q ? BUBBLE_WORD : rdata;
  assign d_rsp_data  = rdata;
  assign bubble      = bubble_q;
endmodule

// File: rtl/shmem_stall_counter.sv
module shmem_stall_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] CMAX = '1;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (inc && (cnt_q != CMAX)) cnt_q <= cnt_q + 1'b1;
  end

  assign count = cnt_q;
endmodule

// File: rtl/shmem_arbiter.sv
module shmem_arbiter
  import shmem_arbiter_pkg::*;
#(
  parameter int            AW          = 8,
  parameter int            DW          = 32,
  parameter int            CW          = 16,
  parameter logic [DW-1:0] BUBBLE_WORD = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          if_req_valid,
  output logic          if_req_ready,
  input  logic [AW-1:0] if_addr,
  input  logic          dm_req_valid,
  output logic          dm_req_ready,
  input  logic          dm_we,
  input  logic [AW-1:0] dm_addr,
  input  logic [DW-1:0] dm_wdata,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          if_rsp_valid,
  output logic [DW-1:0] if_rsp_data,
  output logic          dm_rsp_valid,
  output logic [DW-1:0] dm_rsp_data,
  output logic          fetch_stall,
  output logic          id_bubble,
  output logic [CW-1:0] stall_count
);
  grant_e grant;
  logic   collide;

  shmem_grant_logic #(.AW(AW), .DW(DW)) u_grant (
    .f_valid    (if_req_valid),
    .f_addr     (if_addr),
    .d_valid    (dm_req_valid),
    .d_we       (dm_we),
    .d_addr     (dm_addr),
    .d_wdata    (dm_wdata),
    .grant      (grant),
    .f_ready    (if_req_ready),
    .collide    (collide),
    .port_en    (mem_en),
    .port_we    (mem_we),
    .port_addr  (mem_addr),
    .port_wdata (mem_wdata)
  );

  shmem_resp_router #(.DW(DW), .BUBBLE_WORD(BUBBLE_WORD)) u_route (
    .clk         (clk),
    .rst_n       (rst_n),
    .grant       (grant),
    .collide     (collide),
    .rdata       (mem_rdata),
    .f_rsp_valid (if_rsp_valid),
    .f_rsp_data  (if_rsp_data),
    .d_rsp_valid (dm_rsp_valid),
    .d_rsp_data  (dm_rsp_data),
    .bubble      (id_bubble)
  );

  shmem_stall_counter #(.CW(CW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (collide),
    .count (stall_count)
  );

  assign dm_req_ready = 1'b1;
  assign fetch_stall  = collide;
endmodule

// File: rtl/shmem_arbiter_checker.sv
module shmem_arbiter_checker #(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          if_req_valid,
  input logic          if_req_ready,
  input logic          dm_req_valid,
  input logic          dm_req_ready,
  input logic          dm_we,
  input logic [AW-1:0] dm_addr,
  input logic          mem_en,
  input logic [AW-1:0] mem_addr,
  input logic          if_rsp_valid,
  input logic          dm_rsp_valid,
  input logic          fetch_stall,
  input logic          id_bubble,
  input logic [CW-1:0] stall_count
);
  localparam logic [CW-1:0] CMAX = '1;

  p_data_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dm_req_valid |-> (dm_req_ready && mem_en && mem_addr == dm_addr));

  p_fetch_alone_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (if_req_valid && !dm_req_valid) |-> (if_req_ready && mem_en && !fetch_stall));

  p_collide_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (if_req_valid && dm_req_valid) |-> (fetch_stall && !if_req_ready));

  p_load_rsp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dm_req_valid && !dm_we) |=> (dm_rsp_valid && !if_rsp_valid));

  p_store_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dm_req_valid && dm_we) |=> (!dm_rsp_valid && !if_rsp_valid));

  p_rsp_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({if_rsp_valid, dm_rsp_valid}));

  p_bubble_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_stall |=> (id_bubble && !if_rsp_valid));

  p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_stall && stall_count != CMAX) |=> (stall_count == $past(stall_count) + 1'b1));

  p_count_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_stall |=> $stable(stall_count));
endmodule

bind shmem_arbiter shmem_arbiter_checker #(.AW(AW), .DW(DW), .CW(CW)) u_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .if_req_valid (if_req_valid),
  .if_req_ready (if_req_ready),
  .dm_req_valid (dm_req_valid),
  .dm_req_ready (dm_req_ready),
  .dm_we        (dm_we),
  .dm_addr      (dm_addr),
  .mem_en       (mem_en),
  .mem_addr     (mem_addr),
  .if_rsp_valid (if_rsp_valid),
  .dm_rsp_valid (dm_rsp_valid),
  .fetch_stall  (fetch_stall),
  .id_bubble    (id_bubble),
  .stall_count  (stall_count)
);

// File: tb/test_shmem_arbiter.sv
module test_shmem_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int DW = 32;
  localparam int CW = 4;
  localparam int DEPTH = 1 << AW;
  localparam logic [CW-1:0] CMAX = '1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          if_req_valid = 1'b0;
  logic          if_req_ready;
  logic [AW-1:0] if_addr = '0;
  logic          dm_req_valid = 1'b0;
  logic          dm_req_ready;
  logic          dm_we = 1'b0;
  logic [AW-1:0] dm_addr = '0;
  logic [DW-1:0] dm_wdata = '0;
  logic          mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata;
  logic          if_rsp_valid, dm_rsp_valid, fetch_stall, id_bubble;
  logic [DW-1:0] if_rsp_data, dm_rsp_data;
  logic [CW-1:0] stall_count;

  int checks = 0;
  int errors = 0;
  int exp_cnt = 0;
  logic [DW-1:0] shadow [DEPTH];
  logic [DW-1:0] mem_arr [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  shmem_arbiter #(.AW(AW), .DW(DW), .CW(CW)) i_shmem_arbiter (
    .clk(clk), .rst_n(rst_n),
    .if_req_valid(if_req_valid), .if_req_ready(if_req_ready), .if_addr(if_addr),
    .dm_req_valid(dm_req_valid), .dm_req_ready(dm_req_ready), .dm_we(dm_we),
    .dm_addr(dm_addr), .dm_wdata(dm_wdata),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata),
    .if_rsp_valid(if_rsp_valid), .if_rsp_data(if_rsp_data),
    .dm_rsp_valid(dm_rsp_valid), .dm_rsp_data(dm_rsp_data),
    .fetch_stall(fetch_stall), .id_bubble(id_bubble), .stall_count(stall_count)
  );

  // memory model with one cycle of read latency
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem_arr[mem_addr] <= mem_wdata;
      else        mem_rdata <= mem_arr[mem_addr];
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check port side, clock, check responses
  task automatic step(input bit fv, input bit dv, input bit dwe,
                      input logic [AW-1:0] fa, input logic [AW-1:0] da,
                      input logic [DW-1:0] wd);
    bit col;
    @(negedge clk);
    if_req_valid = fv; if_addr = fa;
    dm_req_valid = dv; dm_we = dwe; dm_addr = da; dm_wdata = wd;
    col = fv && dv;
    #1;
    if (dv) begin
      chk(dm_req_ready == 1'b1, "R2", "dm_req_ready", 32'(dm_req_ready), 32'd1);
      chk(mem_en && mem_we == dwe && mem_addr == da, "R2", "data port steer",
          32'({mem_en, mem_we, mem_addr}), 32'({1'b1, dwe, da}));
      if (dwe) chk(mem_wdata == wd, "R2", "store data", mem_wdata, wd);
    end else if (fv) begin
      chk(mem_en && !mem_we && mem_addr == fa && if_req_ready && !fetch_stall,
          "R3", "fetch port", 32'({mem_en, mem_we, if_req_ready, fetch_stall, mem_addr}),
          32'({1'b1, 1'b0, 1'b1, 1'b0, fa}));
    end else begin
      chk(!mem_en, "R3", "idle port", 32'(mem_en), 32'd0);
    end
    if (col)
      chk(fetch_stall && !if_req_ready, "R4", "collision stall",
          32'({fetch_stall, if_req_ready}), 32'b10);
    @(posedge clk);
    #1;
    if (col && exp_cnt < int'(CMAX)) exp_cnt++;
    chk(stall_count == CW'(exp_cnt), "R7", "stall_count", 32'(stall_count), 32'(exp_cnt));
    chk(id_bubble == col, "R6", "id_bubble", 32'(id_bubble), 32'(col));
    if (col)
      chk(!if_rsp_valid && if_rsp_data == '0, "R6", "bubble word",
          if_rsp_data, 32'd0);
    if (dv && !dwe) begin
      chk(dm_rsp_valid && !if_rsp_valid, "R5", "load valids",
          32'({dm_rsp_valid, if_rsp_valid}), 32'b10);
      chk(dm_rsp_data == shadow[da], "R5", "load data", dm_rsp_data, shadow[da]);
    end else if (dv && dwe) begin
      chk(!dm_rsp_valid && !if_rsp_valid, "R5", "store quiet",
          32'({dm_rsp_valid, if_rsp_valid}), 32'b00);
      shadow[da] = wd;
    end else if (fv) begin
      chk(if_rsp_valid && !dm_rsp_valid, "R5", "fetch valids",
          32'({if_rsp_valid, dm_rsp_valid}), 32'b10);
      chk(if_rsp_data == shadow[fa], "R5", "fetch data", if_rsp_data, shadow[fa]);
    end else begin
      chk(!if_rsp_valid && !dm_rsp_valid, "R5", "idle valids",
          32'({if_rsp_valid, dm_rsp_valid}), 32'b00);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      shadow[i]  = 32'hC3000000 ^ (32'(i) * 32'h00010203);
      mem_arr[i] = 32'hC3000000 ^ (32'(i) * 32'h00010203);
    end
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk(!mem_en && !if_rsp_valid && !dm_rsp_valid && !id_bubble && stall_count == '0,
        "R1", "reset outputs",
        32'({mem_en, if_rsp_valid, dm_rsp_valid, id_bubble, stall_count}), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // exhaustive sweep of request combinations, several address patterns
    for (int p = 0; p < 4; p++) begin
      for (int c = 0; c < 8; c++) begin
        step(c[0], c[1], c[2], AW'(c * 3 + p * 5), AW'(c * 7 + p), 32'h5A000000 + 32'(p * 16 + c));
      end
    end

    // R8: stalled fetch retried with the same address
    step(1'b1, 1'b1, 1'b0, 4'd9, 4'd2, 32'd0);
    step(1'b1, 1'b0, 1'b0, 4'd9, 4'd0, 32'd0);
    chk(if_rsp_data == shadow[9], "R8", "retried fetch word", if_rsp_data, shadow[9]);
    step(1'b1, 1'b1, 1'b1, 4'd11, 4'd11, 32'hDEAD0011);
    step(1'b1, 1'b0, 1'b0, 4'd11, 4'd0, 32'd0);
    chk(if_rsp_data == 32'hDEAD0011, "R8", "retry sees store", if_rsp_data, 32'hDEAD0011);

    // R7: back-to-back collisions drive the counter to saturation
    for (int k = 0; k < 20; k++) begin
      step(1'b1, 1'b1, k[0], 4'd5, AW'(k), 32'hB0000000 + 32'(k));
    end
    chk(stall_count == CMAX, "R7", "saturated count", 32'(stall_count), 32'(CMAX));

    step(1'b0, 1'b0, 1'b0, 4'd0, 4'd0, 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule